// File: doc/BRIEF.md
# Segmentable Tapped Serial Shift Register

This block is a 64-stage serial shift register with a tap after every sixteenth stage. It has no reset: it holds whatever it was last clocked with, and it holds that indefinitely when the clock stops. A single mode input picks one of two configurations.

In serial mode the four taps are driven outputs, and the register is one continuous 64-stage chain. In segmented mode the tap drivers are released and the taps act as inputs. The chain then splits into four independent 16-stage segments. Each segment after the first is fed from the tap pin at the end of the segment before it.

Each bidirectional tap pin is modelled as three signals: a data-out bit, an output-enable bit and a data-in bit. On every rising edge the serial input enters the first stage, whatever the mode. The mode is sampled at that same edge.

Top module: `tapped_shift_reg`

## Requirements
- R1: The register has 64 stages arranged as four 16-stage segments. Bit k of `tap_out` (k = 0..3) shows the content of stage 16·(k+1), where stage 1 is the entry stage. It changes only at rising clock edges.
- R2: On every rising edge, stage 1 takes `din`, whether `mode_seg` is 0 or 1.
- R3: With `mode_seg` = 0 (serial) at an edge, stages 17, 33 and 49 take the previous content of stages 16, 32 and 48. This forms one continuous 64-stage chain.
- R4: `tap_oe` is 4'b1111 while `mode_seg` is 0 and 4'b0000 while `mode_seg` is 1. It follows the input without waiting for a clock edge.
- R5: With `mode_seg` = 1 (segmented) at an edge, stages 17, 33 and 49 take `tap_in[0]`, `tap_in[1]` and `tap_in[2]`. Here `tap_in[k]` is the input side of the tap at stage 16·(k+1).
- R6: `tap_in[3]` never affects the contents. All of `tap_in` is ignored when `mode_seg` is 0.
- R7: At every edge in either mode, each stage that is not the first of its segment takes the previous content of the stage before it.
- R8: `mode_seg` is sampled at the rising edge. A change between edges affects only the shift at the next edge.
- R9: With no rising edge applied, the contents and `tap_out` hold, whatever `din`, `mode_seg` and `tap_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| mode_seg | input | 1 | 0 = serial 64-stage chain, 1 = four segments with taps as inputs |
| din | input | 1 | Serial data into stage 1 |
| tap_in | input | 4 | Input side of the four tap pins |
| tap_out | output | 4 | Output side of the four tap pins (stages 16, 32, 48, 64) |
| tap_oe | output | 4 | Output-enable of the four tap pins |

## Verification
On every clock, the assertions check the entry stage, the shift inside each segment, and the source of each segment boundary. For the boundaries they confirm the previous tail in serial mode and the external tap bit in segmented mode. Only the bench scenarios can show the rest. This covers end-to-end agreement of the tap outputs with a 64-bit reference model, and the complete neglect of `tap_in[3]` and of serial-mode tap inputs. It also covers mode switches in mid-stream and retention with the clock stopped.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic {
    MODE_SERIAL    = 1'b0,
    MODE_SEGMENTED = 1'b1
  } tsr_mode_e;

  // Index (0-based) of the last stage in segment k.
  function automatic int unsigned seg_tail_idx(int unsigned k, int unsigned seg_len);
    return (k + 1) * seg_len - 1;
  endfunction

  // Index (0-based) of the first stage in segment k.
  function automatic int unsigned seg_head_idx(int unsigned k, int unsigned seg_len);
    return k * seg_len;
  endfunction

  // Source of a segment head: the external tap bit when segmented, else the chain.
  function automatic logic pick_head(tsr_mode_e mode, logic chain_bit, logic ext_bit);
    return (mode == MODE_SEGMENTED) ? ext_bit : chain_bit;
  endfunction

endpackage

// File: rtl/tsr_head_sel.sv
module tsr_head_sel
  import tsr_pkg::*;
(
  input  logic mode_seg,
  input  logic prev_tail,
  input  logic ext_in,
  output logic head
);

  tsr_mode_e mode;
  assign mode = tsr_mode_e'(mode_seg);

  always_comb begin
    head = pick_head(mode, prev_tail, ext_in);
  end

endmodule

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int unsigned SEG_LEN = 16
) (
  input  logic               clk,
  input  logic               head_in,
  output logic [SEG_LEN-1:0] q,
  output logic               tail
);

  always_ff @(posedge clk) begin
    q <= {q[SEG_LEN-2:0], head_in};
  end

  assign tail = q[SEG_LEN-1];

  // Becomes 1 after the first edge, so $past is never read before it is valid.
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_SEG_INNER_SHIFT: assert property (@(posedge clk) disable iff (!past_ok)
    q[SEG_LEN-1:1] == $past(q[SEG_LEN-2:0])); // R7

  AST_SEG_HEAD_LOAD: assert property (@(posedge clk) disable iff (!past_ok)
    q[0] == $past(head_in)); // R7

endmodule

// File: rtl/tapped_shift_reg.sv
module tapped_shift_reg
  import tsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               mode_seg,
  input  logic               din,
  input  logic [NUM_SEG-1:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);

  localparam int unsigned TOTAL = SEG_LEN * NUM_SEG;

  logic [NUM_SEG-1:0] seg_head;
  logic [NUM_SEG-1:0] seg_tail;
  logic [TOTAL-1:0]   stages;

  // The last tap feeds no further segment; its input side goes nowhere.
  logic unused_last_tap_in;
  assign unused_last_tap_in = tap_in[NUM_SEG-1];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    if (g == 0) begin : g_entry
      assign seg_head[g] = din;
    end else begin : g_link
      tsr_head_sel u_head (
        .mode_seg  (mode_seg),
        .prev_tail (seg_tail[g-1]),
        .ext_in    (tap_in[g-1]),
        .head      (seg_head[g])
      );
    end

    tsr_segment #(.SEG_LEN(SEG_LEN)) u_segment (
      .clk     (clk),
      .head_in (seg_head[g]),
      .q       (stages[seg_tail_idx(g, SEG_LEN):seg_head_idx(g, SEG_LEN)]),
      .tail    (seg_tail[g])
    );
  end

  assign tap_out = seg_tail;
  assign tap_oe  = {NUM_SEG{~mode_seg}};

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_ENTRY_TAKES_DIN: assert property (@(posedge clk) disable iff (!past_ok)
    stages[0] == $past(din)); // R2

  for (genvar b = 1; b < NUM_SEG; b++) begin : g_bound_chk
    AST_SERIAL_BOUNDARY: assert property (@(posedge clk) disable iff (!past_ok)
      !$past(mode_seg) |-> stages[b*SEG_LEN] == $past(stages[b*SEG_LEN-1])); // R3

    AST_SEGMENT_BOUNDARY: assert property (@(posedge clk) disable iff (!past_ok)
      $past(mode_seg) |-> stages[b*SEG_LEN] == $past(tap_in[b-1])); // R5
  end

  AST_TAP_MIRRORS_STAGE: assert property (@(posedge clk) disable iff (!past_ok)
    tap_out[NUM_SEG-1] == stages[TOTAL-1]); // R1

endmodule

// File: tb/tapped_shift_reg_bench.sv
module tapped_shift_reg_bench;

  localparam int SEG = 16;
  localparam int NS  = 4;
  localparam int TOT = SEG * NS;

  logic          clk = 1'b0;
  logic          run = 1'b1;
  logic          mode_seg = 1'b0;
  logic          din = 1'b0;
  logic [NS-1:0] tap_in = '0;
  logic [NS-1:0] tap_out;
  logic [NS-1:0] tap_oe;

  int n_checks = 0;
  int n_fails  = 0;
  logic [TOT-1:0] mdl = '0;   // bench reference: bit i = stage i+1
  bit filled = 1'b0;
  bit done = 1'b0;

  always #2 if (run) clk = ~clk;   // 250 MHz

  tapped_shift_reg #(.SEG_LEN(SEG), .NUM_SEG(NS)) u_tapped_shift_reg (
    .clk(clk), .mode_seg(mode_seg), .din(din),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  task automatic chk_oe();
    logic [NS-1:0] exp;
    exp = mode_seg ? '0 : '1;
    n_checks++;
    if (tap_oe !== exp) begin
      n_fails++;
      $display("FAIL R4 tap_oe act=%b exp=%b", tap_oe, exp);
    end
  endtask

  task automatic chk_taps(input string tag);
    if (!filled) return;
    for (int k = 0; k < NS; k++) begin
      n_checks++;
      if (tap_out[k] !== mdl[SEG*k + SEG - 1]) begin
        n_fails++;
        $display("FAIL %s R1 R7 %s tap%0d act=%b exp=%b", tag,
                 (k == 0) ? "R2" : "", k, tap_out[k], mdl[SEG*k + SEG - 1]);
      end
    end
  endtask

  // Called at a falling edge: drive, clock once, update model, check at next fall.
  task automatic step(input logic d, input logic m, input logic [NS-1:0] ti, input string tag);
    logic [TOT-1:0] nx;
    din = d; mode_seg = m; tap_in = ti;
    #1 chk_oe();
    @(posedge clk);
    nx = mdl << 1;
    nx[0] = d;
    if (m) begin
      for (int k = 1; k < NS; k++) nx[SEG*k] = ti[k-1];
    end
    mdl = nx;
    @(negedge clk);
    chk_taps(tag);
  endtask

  function automatic logic [NS-1:0] rnd4();
    logic [31:0] r;
    r = $urandom;
    return r[NS-1:0];
  endfunction

  function automatic logic rnd1();
    logic [31:0] r;
    r = $urandom;
    return r[0];
  endfunction

  initial begin
    @(negedge clk);
    // Fill: 64 known bits in serial mode, tap inputs toggling (R6).
    for (int i = 0; i < TOT; i++) step(((i % 3) == 0) || ((i % 7) == 2), 1'b0, rnd4(), "R3");
    filled = 1'b1;
    chk_taps("R1 fill");
    // Serial, random data and random (ignored) tap inputs.
    for (int i = 0; i < 120; i++) step(rnd1(), 1'b0, rnd4(), "R3 R6");
    // Segmented, random taps including tap_in[3].
    for (int i = 0; i < 120; i++) step(rnd1(), 1'b1, rnd4(), "R5 R6");
    // Near-exhaustive segmented sweep of all tap input codes.
    for (int c = 0; c < 16; c++)
      for (int j = 0; j < 17; j++) step(j[0], 1'b1, c[NS-1:0], "R5 R6");
    // Mode switches mid-stream (R8).
    for (int i = 0; i < 90; i++) step(rnd1(), ((i / 3) % 2) == 1, rnd4(), "R8");
    for (int i = 0; i < 40; i++) step(rnd1(), i[0], rnd4(), "R8");
    // Clock stopped: inputs wiggle, contents must hold (R9).
    run = 1'b0;
    for (int i = 0; i < 10; i++) begin
      #7 din = rnd1(); mode_seg = rnd1(); tap_in = rnd4();
      #1 chk_oe();
      chk_taps("R9 hold");
    end
    mode_seg = 1'b0;
    run = 1'b1;
    for (int i = 0; i < 70; i++) step(rnd1(), 1'b0, rnd4(), "R9 resume");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule